// File: doc/BRIEF.md
# Reference Pulse Divider with Loss Monitor

This block turns a fast input clock into a slow reference pulse train. At 8 MHz its default setting gives 1.5625 kHz. A synchronous binary prescaler divides the clock by 1024 and brings out its top bit as a 7.8125 kHz tap. Each time the prescaler rolls over, it advances a modulo-five stage, so the chain divides by 5120 in all. When the modulo-five stage rolls over, an output shaper starts a pulse that lasts exactly eight input clocks (1 µs). This sets the pulse duration and leaves the repetition rate unchanged.

A clock-enable input stands in for the presence of the input clock. While it is low, the prescaler, the modulo-five stage and the shaper all hold their state. A separate watchdog runs on every clock. It counts the time since the last rising edge of the reference pulse and raises a failure flag once two nominal periods pass with no edge. A lamp-test input forces the failure flag high at any time.

Top module: `refclk_divider`

## Requirements
- R1: The prescaler is a 10-bit counter that advances by one on every clock edge where clk_en is high. pre_tap is its most significant bit, so pre_tap is high while the count (enabled edges since reset, modulo 1024) is 512 to 1023.
- R2: ref_pulse rises once every 5120 enabled edges. The first rising edge becomes visible right after the 5120th enabled edge following reset.
- R3: Each ref_pulse stays high for exactly 8 enabled clock edges and then returns low.
- R4: The shaping does not change the rate: successive rising edges stay 5120 enabled edges apart, and a pulse has always ended before the next rollover of the modulo-five stage.
- R5: While clk_en is low, the prescaler, the modulo-five stage and ref_pulse keep their values.
- R6: The watchdog advances on every clock edge, whether clk_en is high or low. fail_lamp goes high after the 10240th edge with no rising edge of ref_pulse, counted from reset or from the edge that follows the last rising edge.
- R7: Once a new rising edge of ref_pulse is seen, the loss indication clears at the next clock edge.
- R8: lamp_test high drives fail_lamp high in the same cycle, whatever state the watchdog is in.
- R9: A synchronous reset clears every counter and the output register: ref_pulse, pre_tap and fail_lamp are low while rst is high and lamp_test is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock (8 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Input-clock presence; low freezes the divider chain and the shaper |
| lamp_test | input | 1 | Forces fail_lamp high |
| ref_pulse | output | 1 | Reference pulse, 8 clocks wide, once per 5120 enabled clocks |
| pre_tap | output | 1 | Prescaler tap, square wave at 1/1024 of the enabled clock |
| fail_lamp | output | 1 | Reference-loss indication or lamp test |

## Verification
The assertions check on every cycle that:
- each stage freezes while clk_en is low;
- the prescaler and the modulo-five stage return to zero after rolling over;
- a pulse only starts one cycle after a rollover, and never overlaps the next one;
- the loss flag rises only as the watchdog count reaches its limit, and drops after a new edge.

Only the bench scenarios can show the absolute timing: where the tap sits, the enabled-cycle position and width of every pulse, and the exact clock on which fail_lamp rises during a long stall and falls again after clk_en returns. The same holds for the lamp-test override while the reference is present and while it is lost.

// File: rtl/refdiv_pkg.sv
`timescale 1ns/1ps
package refdiv_pkg;

   // Input clocks per output period of the divider chain.
   function automatic int unsigned chain_period(int unsigned pre_bits, int unsigned post_div);
      return (32'd1 << pre_bits) * post_div;
   endfunction

   // Input clocks with no reference edge before the loss flag is raised.
   function automatic int unsigned loss_window(int unsigned pre_bits, int unsigned post_div,
                                               int unsigned periods);
      return chain_period(pre_bits, post_div) * periods;
   endfunction

endpackage

// File: rtl/refdiv_prescale.sv
`timescale 1ns/1ps
module refdiv_prescale #(
   parameter int unsigned PRE_BITS = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic clk_en,
   output logic tick,
   output logic tap
);

   logic [PRE_BITS-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (clk_en)
         cnt_q <= cnt_q + PRE_BITS'(1);
   end

   assign tick = clk_en & (&cnt_q);
   assign tap  = cnt_q[PRE_BITS-1];

   // R1: a rollover strobe is followed by an all-zero count
   a_r1_rollover_zero: assert property (@(posedge clk) disable iff (rst)
      tick |=> (cnt_q == '0));

   // R5: no advance while the input clock is absent
   a_r5_prescale_hold: assert property (@(posedge clk) disable iff (rst)
      !clk_en |=> $stable(cnt_q));

endmodule

// File: rtl/refdiv_modn.sv
`timescale 1ns/1ps
module refdiv_modn #(
   parameter int unsigned DIV = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output logic wrap
);

   localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt_q;
   logic          at_top;

   assign at_top = (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (step)
         cnt_q <= at_top ? '0 : cnt_q + CW'(1);
   end

   assign wrap = step & at_top;

   // R2: the state stays inside the modulus
   a_r2_state_range: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, cnt_q} < (CW+1)'(DIV)));

   // R2: a rollover restarts the count at zero
   a_r2_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (cnt_q == '0));

   // R5: no change without a prescaler strobe
   a_r5_modn_hold: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(cnt_q));

endmodule

// File: rtl/refdiv_shaper.sv
`timescale 1ns/1ps
module refdiv_shaper #(
   parameter int unsigned WIDTH_CYC = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic clk_en,
   input  logic fire,
   output logic pulse
);

   generate
      if (WIDTH_CYC == 1) begin : g_single
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (rst)
               pulse_q <= 1'b0;
            else if (clk_en)
               pulse_q <= fire;
         end
         assign pulse = pulse_q;
      end else begin : g_counted
         localparam int unsigned SW = $clog2(WIDTH_CYC + 1);
         logic [SW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (rst)
               left_q <= '0;
            else if (clk_en) begin
               if (fire)
                  left_q <= SW'(WIDTH_CYC);
               else if (left_q != '0)
                  left_q <= left_q - SW'(1);
            end
         end
         assign pulse = (left_q != '0);
      end
   endgenerate

   // R3: a pulse only starts one cycle after a rollover
   a_r3_rise_from_fire: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse) |-> $past(fire));

   // R4: the previous pulse has ended when the next rollover arrives
   a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
      fire |-> !pulse);

   // R5: the output register is frozen with the clock absent
   a_r5_shaper_hold: assert property (@(posedge clk) disable iff (rst)
      !clk_en |=> $stable(pulse));

endmodule

// File: rtl/refdiv_monitor.sv
`timescale 1ns/1ps
module refdiv_monitor #(
   parameter int unsigned LIMIT = 10240
) (
   input  logic clk,
   input  logic rst,
   input  logic pulse,
   input  logic lamp_test,
   output logic fail
);

   localparam int unsigned GW = $clog2(LIMIT + 1);

   logic          pulse_d_q;
   logic [GW-1:0] gap_q;
   logic          rise;
   logic          lost;

   assign rise = pulse & ~pulse_d_q;
   assign lost = (gap_q == GW'(LIMIT));

   always_ff @(posedge clk) begin
      if (rst) begin
         pulse_d_q <= 1'b0;
         gap_q     <= '0;
      end else begin
         pulse_d_q <= pulse;
         if (rise)
            gap_q <= '0;
         else if (!lost)
            gap_q <= gap_q + GW'(1);
      end
   end

   assign fail = lost | lamp_test;

   // R6: loss is declared only as the count reaches the window
   a_r6_loss_at_limit: assert property (@(posedge clk) disable iff (rst)
      $rose(lost) |-> ($past(gap_q) == GW'(LIMIT - 1)));

   // R6: loss persists until a new edge arrives
   a_r6_loss_sticky: assert property (@(posedge clk) disable iff (rst)
      (lost && !rise) |=> lost);

   // R7: a fresh edge clears the indication on the next clock
   a_r7_clear_on_edge: assert property (@(posedge clk) disable iff (rst)
      rise |=> !lost);

endmodule

// File: rtl/refclk_divider.sv
`timescale 1ns/1ps
module refclk_divider
   import refdiv_pkg::*;
#(
   parameter int unsigned PRE_BITS     = 10,
   parameter int unsigned POST_DIV     = 5,
   parameter int unsigned PULSE_CYC    = 8,
   parameter int unsigned LOSS_PERIODS = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic clk_en,
   input  logic lamp_test,
   output logic ref_pulse,
   output logic pre_tap,
   output logic fail_lamp
);

   localparam int unsigned PERIOD = chain_period(PRE_BITS, POST_DIV);
   localparam int unsigned LIMIT  = loss_window(PRE_BITS, POST_DIV, LOSS_PERIODS);

   generate
      if (PRE_BITS < 1 || PRE_BITS > 20) begin : g_bad_pre
         $error("refclk_divider: PRE_BITS out of range");
      end
      if (POST_DIV < 2) begin : g_bad_post
         $error("refclk_divider: POST_DIV must be at least 2");
      end
      if (PULSE_CYC < 1 || PULSE_CYC >= PERIOD) begin : g_bad_width
         $error("refclk_divider: PULSE_CYC must be shorter than the output period");
      end
      if (LOSS_PERIODS < 1) begin : g_bad_loss
         $error("refclk_divider: LOSS_PERIODS must be at least 1");
      end
   endgenerate

   logic pre_tick;
   logic post_wrap;

   refdiv_prescale #(.PRE_BITS(PRE_BITS)) u_prescale (
      .clk    (clk),
      .rst    (rst),
      .clk_en (clk_en),
      .tick   (pre_tick),
      .tap    (pre_tap)
   );

   refdiv_modn #(.DIV(POST_DIV)) u_modn (
      .clk  (clk),
      .rst  (rst),
      .step (pre_tick),
      .wrap (post_wrap)
   );

   refdiv_shaper #(.WIDTH_CYC(PULSE_CYC)) u_shaper (
      .clk    (clk),
      .rst    (rst),
      .clk_en (clk_en),
      .fire   (post_wrap),
      .pulse  (ref_pulse)
   );

   refdiv_monitor #(.LIMIT(LIMIT)) u_monitor (
      .clk       (clk),
      .rst       (rst),
      .pulse     (ref_pulse),
      .lamp_test (lamp_test),
      .fail      (fail_lamp)
   );

endmodule

// File: tb/refclk_divider_test.sv
`timescale 1ns/1ps
module refclk_divider_test;

   localparam int CLK_PERIOD = 125;
   localparam int PERIOD_EN  = 5120;   // R2
   localparam int WIDTH_EN   = 8;      // R3
   localparam int LOSS_CLKS  = 10240;  // R6

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clk_en = 1'b0;
   logic lamp_test = 1'b0;
   logic ref_pulse, pre_tap, fail_lamp;

   int n_checks = 0;
   int n_fails  = 0;
   int abs_cnt  = 0;
   int en_cnt   = 0;
   int base     = 0;
   int next_exp = PERIOD_EN;
   int rise_en  = 0;
   bit prev_ref = 1'b0;
   bit done     = 1'b0;
   int exp_q[$];

   refclk_divider uut (
      .clk       (clk),
      .rst       (rst),
      .clk_en    (clk_en),
      .lamp_test (lamp_test),
      .ref_pulse (ref_pulse),
      .pre_tap   (pre_tap),
      .fail_lamp (fail_lamp)
   );

   always #(CLK_PERIOD / 2.0) clk = ~clk;

   // Edge counters: absolute clocks and enabled clocks since reset
   always @(posedge clk) begin
      if (rst) begin
         abs_cnt = 0;
         en_cnt  = 0;
      end else begin
         abs_cnt = abs_cnt + 1;
         if (clk_en) en_cnt = en_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d (abs clock %0d)", req, act, exp, abs_cnt);
      end
   endtask

   task automatic push_rises(input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(next_exp);
         next_exp += PERIOD_EN;
      end
   endtask

   task automatic run(input bit en, input int cycles);
      @(negedge clk);
      clk_en = en;
      repeat (cycles) @(negedge clk);
   endtask

   // Monitor: a quarter period after each rising edge
   always begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (!rst) begin
         int exp_fail;
         exp_fail = (lamp_test || (abs_cnt - base >= LOSS_CLKS)) ? 1 : 0;
         check(fail_lamp == exp_fail, "R6/R7/R8 fail_lamp", fail_lamp, exp_fail);
         if (abs_cnt % 97 == 0) begin
            int exp_tap;
            exp_tap = ((en_cnt % 1024) >= 512) ? 1 : 0;
            check(pre_tap == exp_tap, "R1 pre_tap", pre_tap, exp_tap);
         end
         if (ref_pulse && !prev_ref) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2/R4 unexpected rise", en_cnt, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               check(en_cnt == e, "R2/R4 rise position", en_cnt, e);
            end
            rise_en = en_cnt;
            base = abs_cnt + 1;
         end
         if (!ref_pulse && prev_ref)
            check(en_cnt - rise_en == WIDTH_EN, "R3 pulse width", en_cnt - rise_en, WIDTH_EN);
         prev_ref = ref_pulse;
      end else begin
         prev_ref = 1'b0;
         base = 0;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (4) @(posedge clk);
      #(CLK_PERIOD / 4);
      check(ref_pulse == 1'b0, "R9 ref_pulse in reset", ref_pulse, 0);
      check(pre_tap == 1'b0, "R9 pre_tap in reset", pre_tap, 0);
      check(fail_lamp == 1'b0, "R9 fail_lamp in reset", fail_lamp, 0);
      @(negedge clk);
      rst = 1'b0;

      // R1 R2 R3 with a lamp test R8 while the reference is present
      push_rises(3);
      run(1'b1, 7000);
      lamp_test = 1'b1;
      run(1'b1, 50);
      lamp_test = 1'b0;
      run(1'b1, 8950);

      // R5: short stall, spacing in enabled cycles unchanged, no loss
      run(1'b0, 3000);
      push_rises(2);
      run(1'b1, 10000);

      // R6: long stall raises the flag; R8 lamp test during loss
      run(1'b0, 11000);
      lamp_test = 1'b1;
      run(1'b0, 20);
      lamp_test = 1'b0;
      run(1'b0, 980);

      // R7: reference returns and the flag clears
      push_rises(1);
      run(1'b1, 6000);

      check(exp_q.size() == 0, "R2 all expected rises seen", exp_q.size(), 0);
      check(fail_lamp == 1'b0, "R7 fail_lamp after recovery", fail_lamp, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule